// File: doc/BRIEF.md
# Strided Decimating Window Register

This block collects a moving window of recent samples for a downstream neural-network stage that must see only every STRIDE-th result of the stage in front of it. Samples arrive on a bus with a valid strobe. A stride counter picks one valid sample out of every STRIDE. Each picked sample is shifted into a storage chain NUM_POINTS entries deep.

The whole chain is presented as one concatenated word. A one-cycle flag marks each window that is full and has just advanced. The downstream stage therefore consumes a fresh window exactly when the flag is high. With STRIDE set to 1 the block is a plain valid-gated shift register whose output flag is based on fill level.

Top module: `strided_window_sr`

## Requirements
- R1: An asynchronous reset (rst_n low) clears win_data to zero and win_valid to low, and restarts the stride phase and the fill count, without waiting for a clock edge.
- R2: The first cycle with in_valid high after reset accepts its sample. With in_valid held high, every STRIDE-th cycle after that is accepted, and the cycles in between are ignored.
- R3: The stride phase advances only on cycles with in_valid high. Cycles with in_valid low neither count toward the stride nor produce win_valid.
- R4: On an accepted sample, win_data[DATA_WIDTH-1:0] takes the new sample and each older sample moves up by DATA_WIDTH bits. The sample that was in the most significant slot is discarded.
- R5: win_valid stays low until NUM_POINTS samples have been accepted since reset.
- R6: win_valid is a registered one-cycle pulse. It is high in the cycle after an accepted shift that leaves the buffer full, and low in every other cycle.
- R7: win_data holds its value between accepted shifts. Samples that are ignored by the stride, and cycles with in_valid low, do not change it.
- R8: With STRIDE equal to 1, every cycle with in_valid high is accepted.
- R9: The fill count saturates at NUM_POINTS, so win_valid pulses after every later accepted sample until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe qualifying in_sample |
| in_sample | input | DATA_WIDTH | Incoming sample |
| win_data | output | DATA_WIDTH*NUM_POINTS | Concatenated window, newest sample in the low bits |
| win_valid | output | 1 | One-cycle pulse marking a full, freshly advanced window |

## Verification
The first stimulus holds the strobe high on every cycle. This separates a correct stride phase from one that is off by a cycle, and shows the fill threshold of R5. Stretches with the strobe low, including gaps that fall inside a stride period, separate a counter that advances only on valid samples from one that runs freely. A random mix of strobe and data, applied to a stride-3 instance and a stride-1 instance, tests the shift ordering, the saturating fill and the holding behaviour over long runs. A reset applied in mid-run, checked before the next clock edge, confirms that the reset is asynchronous and that the block restarts cleanly afterwards.

// File: rtl/strided_window_pkg.sv
package strided_window_pkg;
   // width of a counter able to hold values 0 .. n-1, never below one bit
   function automatic int unsigned ctr_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // width able to hold values 0 .. n
   function automatic int unsigned lvl_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/stride_gate.sv
module stride_gate #(
   parameter int unsigned STRIDE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   output logic take
);
   import strided_window_pkg::*;

   localparam int unsigned PH_W = ctr_bits(STRIDE);

   generate
      if (STRIDE == 1) begin : g_pass
         assign take = valid;
      end else begin : g_count
         logic [PH_W-1:0] phase_q;
         localparam logic [PH_W-1:0] LAST = PH_W'(STRIDE - 1);

         assign take = valid && (phase_q == '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (valid) begin
               phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
   parameter int unsigned NUM_POINTS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   output logic full_after,
   output logic [strided_window_pkg::lvl_bits(NUM_POINTS)-1:0] level
);
   import strided_window_pkg::*;

   localparam int unsigned LV_W = lvl_bits(NUM_POINTS);
   localparam logic [LV_W-1:0] TOP  = LV_W'(NUM_POINTS);
   localparam logic [LV_W-1:0] NEAR = LV_W'(NUM_POINTS - 1);

   logic [LV_W-1:0] level_q;

   assign level      = level_q;
   assign full_after = take && (level_q >= NEAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else if (take && (level_q != TOP)) begin
         level_q <= level_q + 1'b1;
      end
   end
endmodule

// File: rtl/window_shifter.sv
module window_shifter #(
   parameter int unsigned DATA_WIDTH = 2,
   parameter int unsigned NUM_POINTS = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             take,
   input  logic [DATA_WIDTH-1:0]            sample,
   output logic [DATA_WIDTH*NUM_POINTS-1:0] window
);
   localparam int unsigned WW = DATA_WIDTH * NUM_POINTS;

   logic [WW-1:0] win_q;
   assign window = win_q;

   generate
      if (NUM_POINTS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    win_q <= '0;
            else if (take) win_q <= sample;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    win_q <= '0;
            else if (take) win_q <= {win_q[WW-DATA_WIDTH-1:0], sample};
         end
      end
   endgenerate
endmodule

// File: rtl/strided_window_sr.sv
module strided_window_sr #(
   parameter int unsigned DATA_WIDTH = 2,
   parameter int unsigned NUM_POINTS = 3,
   parameter int unsigned STRIDE     = 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   input  logic [DATA_WIDTH-1:0]            in_sample,
   output logic [DATA_WIDTH*NUM_POINTS-1:0] win_data,
   output logic                             win_valid
);
   import strided_window_pkg::*;

   localparam int unsigned LV_W = lvl_bits(NUM_POINTS);

   generate
      if (DATA_WIDTH < 1) begin : g_bad_width
         $error("strided_window_sr: DATA_WIDTH must be at least 1");
      end
      if (NUM_POINTS < 1) begin : g_bad_depth
         $error("strided_window_sr: NUM_POINTS must be at least 1");
      end
      if (STRIDE < 1) begin : g_bad_stride
         $error("strided_window_sr: STRIDE must be at least 1");
      end
   endgenerate

   logic            take;
   logic            full_after;
   logic [LV_W-1:0] fill_lvl;
   logic            pulse_q;

   stride_gate #(.STRIDE(STRIDE)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (in_valid),
      .take  (take)
   );

   fill_tracker #(.NUM_POINTS(NUM_POINTS)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .full_after (full_after),
      .level      (fill_lvl)
   );

   window_shifter #(.DATA_WIDTH(DATA_WIDTH), .NUM_POINTS(NUM_POINTS)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .sample (in_sample),
      .window (win_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= full_after;
   end

   assign win_valid = pulse_q;
endmodule

// File: rtl/strided_window_sr_chk.sv
module strided_window_sr_chk #(
   parameter int unsigned DATA_WIDTH = 2,
   parameter int unsigned NUM_POINTS = 3,
   parameter int unsigned STRIDE     = 1,
   parameter int unsigned LV_W       = 2
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             in_valid,
   input logic [DATA_WIDTH-1:0]            in_sample,
   input logic [DATA_WIDTH*NUM_POINTS-1:0] win_data,
   input logic                             win_valid,
   input logic [LV_W-1:0]                  fill_lvl
);
   localparam int unsigned WW = DATA_WIDTH * NUM_POINTS;

   // R6
   pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> $past(in_valid));

   // R4
   newest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_data[DATA_WIDTH-1:0] == $past(in_sample)));

   // R7
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(win_data));

   // R3
   no_pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !win_valid);

   // R5
   full_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (fill_lvl == LV_W'(NUM_POINTS)));

   generate
      if (NUM_POINTS > 1) begin : g_shift_chk
         // R4
         older_move_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
            win_valid |-> (win_data[WW-1:DATA_WIDTH] == $past(win_data[WW-DATA_WIDTH-1:0])));
      end
      if (STRIDE > 1) begin : g_pulse_chk
         // R2
         single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            win_valid |=> !win_valid);
      end
   endgenerate
endmodule

bind strided_window_sr strided_window_sr_chk #(
   .DATA_WIDTH (DATA_WIDTH),
   .NUM_POINTS (NUM_POINTS),
   .STRIDE     (STRIDE),
   .LV_W       (LV_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sample (in_sample),
   .win_data  (win_data),
   .win_valid (win_valid),
   .fill_lvl  (fill_lvl)
);

// File: tb/strided_window_sr_tb.sv
module strided_window_sr_tb;
   localparam int unsigned W  = 4;
   localparam int unsigned N  = 3;
   localparam int unsigned S  = 3;
   localparam int unsigned WW = W * N;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  in_sample = '0;
   logic [WW-1:0] win_a, win_b;
   logic          vld_a, vld_b;

   int checks = 0;
   int errors = 0;
   string tag = "R1";

   // expected state: index 0 = stride S instance, index 1 = stride 1 instance
   int            ph   [2];
   int            fill [2];
   logic [WW-1:0] ewin [2];
   logic          evld [2];

   always #2 clk = ~clk;

   strided_window_sr #(.DATA_WIDTH(W), .NUM_POINTS(N), .STRIDE(S)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .win_data(win_a), .win_valid(vld_a));

   strided_window_sr #(.DATA_WIDTH(W), .NUM_POINTS(N), .STRIDE(1)) u_dut_s1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .win_data(win_b), .win_valid(vld_b));

   function automatic logic [WW-1:0] push(input logic [WW-1:0] w, input logic [W-1:0] d);
      return {w[WW-W-1:0], d};
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         ph[k] = 0; fill[k] = 0; ewin[k] = '0; evld[k] = 1'b0;
      end
   endtask

   task automatic model_edge(input bit v, input logic [W-1:0] d);
      for (int k = 0; k < 2; k++) begin
         int st = (k == 0) ? S : 1;
         evld[k] = 1'b0;
         if (v) begin
            if (ph[k] == 0) begin
               ewin[k] = push(ewin[k], d);
               if (fill[k] < N) fill[k]++;
               evld[k] = (fill[k] == N);
            end
            ph[k] = (ph[k] + 1) % st;
         end
      end
   endtask

   task automatic check_all(input string t);
      checks += 4;
      if (win_a !== ewin[0]) begin
         errors++; $display("FAIL %s stride%0d win_data got %h exp %h", t, S, win_a, ewin[0]);
      end
      if (vld_a !== evld[0]) begin
         errors++; $display("FAIL %s stride%0d win_valid got %b exp %b", t, S, vld_a, evld[0]);
      end
      if (win_b !== ewin[1]) begin
         errors++; $display("FAIL %s R8 stride1 win_data got %h exp %h", t, win_b, ewin[1]);
      end
      if (vld_b !== evld[1]) begin
         errors++; $display("FAIL %s R8 stride1 win_valid got %b exp %b", t, vld_b, evld[1]);
      end
   endtask

   task automatic step(input bit v, input logic [W-1:0] d);
      in_valid  = v;
      in_sample = d;
      @(posedge clk);
      #1;
      model_edge(v, d);
      check_all(tag);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired checks %0d exp finish", checks);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0017));
      model_reset();
      #1;
      tag = "R1 reset state";
      check_all(tag);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R5 R6: strobe held high, stride 3 takes cycles 0,3,6,...
      tag = "R2 R5 R6 held valid";
      for (int i = 0; i < 14; i++) step(1'b1, W'(i + 1));

      // R3 R7: gaps inside a stride period, data changing while idle
      tag = "R3 R7 idle gaps";
      for (int i = 0; i < 4; i++) step(1'b0, W'(4'hA + i));
      step(1'b1, 4'h5);
      step(1'b0, 4'hF);
      step(1'b1, 4'h6);
      step(1'b0, 4'hE);
      step(1'b0, 4'hD);
      step(1'b1, 4'h7);
      step(1'b1, 4'h8);

      // R1: asynchronous reset mid-run, checked before any clock edge
      rst_n = 1'b0;
      #0.5;
      model_reset();
      tag = "R1 async reset";
      check_all(tag);
      @(negedge clk);
      rst_n = 1'b1;

      // R5: fill needs N accepts after reset
      tag = "R5 refill";
      for (int i = 0; i < 9; i++) step(1'b1, W'(4'h9 - i));

      // R4 R9 R8: random mix
      tag = "R4 R9 R8 random";
      for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, W'($urandom));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule